// File: doc/BRIEF.md
# I2C Master Address-Phase Sequencer

This block is the front end of an I2C bus master. It opens a transaction, sends the slave address in 7-bit or 10-bit form, and collects the slave's acknowledge for each address byte. Software-style register writes load the first address byte, the second 10-bit address byte, an optional prefix byte and a 16-bit clock divider. Writing the first address byte starts the sequence. The bus is driven through two drive-low enables, one for SCL and one for SDA. The sampled SDA line is read back to detect ACK or NACK.

A transaction begins with START. If a prefix byte was written since the previous transaction, the block sends that byte, gives it a ninth clock whose response is ignored, and issues a repeated START. It then sends one address byte, or two in 10-bit mode, each followed by an acknowledge clock. A NACK ends the transaction at once with STOP and raises a sticky nack flag. When the last address byte is acknowledged, a one-cycle done pulse is raised and the block closes with STOP. The data phase that follows is handled by a separate block.

The register write port is control, not a stream. It has no back-pressure: a write that arrives while `busy` is high is dropped.

Top module: `i2c_addr_seq`

## Requirements
- R1: After reset, both drive-low enables are off and busy, done and nack are low. The divider holds 0x1F1F, so both SCL phases last 32 cycles. The first, second and prefix byte registers hold 0x00.
- R2: A write with wr_sel=0 while idle stores wr_data[7:0] as the first address byte and starts a transaction. In the cycle after the write, START appears (SDA driven low, SCL released) and lasts DIVH+1 cycles.
- R3: A write with wr_sel=3 loads DIVH from wr_data[15:8] and DIVL from wr_data[7:0]. Every SCL high phase lasts DIVH+1 cycles and every SCL low phase lasts DIVL+1 cycles.
- R4: Each byte is sent MSB first, one bit per low-then-high SCL slot, with SDA driven low for a 0 bit. SDA changes while SCL is high only for START and STOP. In 7-bit mode the first byte holds the address in bits 7:1 and the direction in bit 0 (1 = read).
- R5: In the ninth slot of every byte, SDA is released. sda_in is sampled in the last cycle of that slot's high phase, and low means ACK.
- R6: When mode_10b is high at the start, the first byte is sent as written, followed by the second address byte (wr_sel=1, wr_data[7:0]). By convention the first byte holds 11110b in bits 7:3, address bits 9:8 in bits 2:1 and the direction in bit 0.
- R7: A NACK on any address byte skips the remaining bytes and issues STOP: DIVL+1 cycles with SCL low and SDA low, then DIVH+1 cycles with SCL released and SDA low, then both released. nack rises in the first STOP cycle and holds until the next start.
- R8: When the final address byte is acknowledged, done is high for exactly the first STOP cycle, and STOP follows.
- R9: A write with wr_sel=2 arms a prefix byte for the next transaction. The transaction then runs as follows:
  - START, the prefix byte, and a ninth slot whose response is ignored.
  - A repeated START: SCL low for DIVL+1 cycles with SDA released, then SCL released for DIVH+1 cycles with SDA released, then SDA low for DIVH+1 cycles.
  - The address bytes.
  The prefix is disarmed when any transaction starts.
- R10: Register writes made while busy have no effect. mode_10b is sampled only in the cycle that starts a transaction.
- R11: busy is high from the first START cycle through the last STOP cycle. Both enables are off while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 first address byte (starts), 1 second address byte, 2 prefix byte, 3 divider |
| wr_data | input | 16 | Write data; byte registers use bits 7:0 |
| mode_10b | input | 1 | 1 selects 10-bit addressing, sampled at start |
| sda_in | input | 1 | Sampled SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse: final address byte acknowledged |
| nack | output | 1 | Sticky flag: an address byte was not acknowledged |

## Verification
The hardest cases to reach are those where the outcome depends on the slave's response in a particular ninth slot. Examples are a NACK on the second 10-bit byte, and a prefix slot whose response must be ignored whether the line is pulled low or not. The bench acts as the slave: its cycle model marks every ninth-slot cycle with the level to drive on sda_in, so each byte can be acknowledged or refused on its own. Ignored writes are reached by writing the divider, the address bytes and the prefix, and by toggling mode_10b, a fixed number of cycles into a running transaction. The following transactions then expose any register that changed.

// File: rtl/i2c_aseq_pkg.sv
package i2c_aseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BLO,    // bit slot, SCL low
    ST_BHI,    // bit slot, SCL high
    ST_RLO,    // repeated start preamble, SCL low
    ST_RHI,    // repeated start preamble, SCL high
    ST_PLO,    // stop, SCL low
    ST_PHI     // stop, SCL high
  } aseq_state_e;

  typedef enum logic [1:0] {
    BY_PRE,
    BY_FIRST,
    BY_SECOND
  } aseq_byte_e;

  localparam logic [1:0] SEL_FIRST  = 2'd0;
  localparam logic [1:0] SEL_SECOND = 2'd1;
  localparam logic [1:0] SEL_PREFIX = 2'd2;
  localparam logic [1:0] SEL_DIV    = 2'd3;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/aseq_regs.sv
module aseq_regs
  import i2c_aseq_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter logic [2*HALF_W-1:0] DIV_RST = 16'h1F1F,
  localparam int DATA_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              go,
  output logic              prefix_pend,
  output logic [BYTE_W-1:0] first_q,
  output logic [BYTE_W-1:0] second_q,
  output logic [BYTE_W-1:0] prefix_q,
  output logic [HALF_W-1:0] div_hi,
  output logic [HALF_W-1:0] div_lo
);

  logic wr_ok;

  assign wr_ok = wr_en && !busy;
  assign go    = wr_ok && (wr_sel == SEL_FIRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q     <= '0;
      second_q    <= '0;
      prefix_q    <= '0;
      div_hi      <= DIV_RST[DATA_W-1:HALF_W];
      div_lo      <= DIV_RST[HALF_W-1:0];
      prefix_pend <= 1'b0;
    end else if (wr_ok) begin
      unique case (wr_sel)
        SEL_FIRST: begin
          first_q     <= wr_data[BYTE_W-1:0];
          prefix_pend <= 1'b0;
        end
        SEL_SECOND: second_q <= wr_data[BYTE_W-1:0];
        SEL_PREFIX: begin
          prefix_q    <= wr_data[BYTE_W-1:0];
          prefix_pend <= 1'b1;
        end
        default: begin
          div_hi <= wr_data[DATA_W-1:HALF_W];
          div_lo <= wr_data[HALF_W-1:0];
        end
      endcase
    end
  end

  // R10
  hold_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> ($stable(div_hi) && $stable(div_lo) && $stable(first_q) &&
                         $stable(second_q) && $stable(prefix_q) && $stable(prefix_pend)));

endmodule

// File: rtl/aseq_timer.sv
module aseq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         last
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= len;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == '0);

endmodule

// File: rtl/aseq_ctrl.sv
module aseq_ctrl
  import i2c_aseq_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              prefix_pend,
  input  logic              mode_10b,
  input  logic [BYTE_W-1:0] first_q,
  input  logic [BYTE_W-1:0] second_q,
  input  logic [BYTE_W-1:0] prefix_q,
  input  logic [HALF_W-1:0] div_hi,
  input  logic [HALF_W-1:0] div_lo,
  input  logic              last,
  input  logic              sda_in,
  output logic              load,
  output logic [HALF_W-1:0] len,
  output logic              scl_dl,
  output logic              sda_dl,
  output logic              busy,
  output logic              done,
  output logic              nack
);

  localparam logic [3:0] ACK_IDX = 4'd8;

  aseq_state_e       state, nxt_state;
  aseq_byte_e        cur, nxt_cur;
  logic [3:0]        bidx, nxt_bidx;
  logic              ten_q;
  logic [BYTE_W-1:0] cur_byte;
  logic              bit_val;
  logic              ack_end;
  logic              nack_now;
  logic              fin_ok;

  always_comb begin
    unique case (cur)
      BY_PRE:   cur_byte = prefix_q;
      BY_FIRST: cur_byte = first_q;
      default:  cur_byte = second_q;
    endcase
  end

  assign bit_val  = cur_byte[3'd7 - bidx[2:0]];
  assign ack_end  = (state == ST_BHI) && last && (bidx == ACK_IDX) && (cur != BY_PRE);
  assign nack_now = ack_end && sda_in;
  assign fin_ok   = ack_end && !sda_in && !((cur == BY_FIRST) && ten_q);

  always_comb begin
    nxt_state = state;
    nxt_cur   = cur;
    nxt_bidx  = bidx;
    load      = 1'b0;
    len       = div_lo;
    unique case (state)
      ST_IDLE: if (go) begin
        nxt_state = ST_START;
        nxt_cur   = prefix_pend ? BY_PRE : BY_FIRST;
        load      = 1'b1;
        len       = div_hi;
      end
      ST_START: if (last) begin
        nxt_state = ST_BLO;
        nxt_bidx  = 4'd0;
        load      = 1'b1;
      end
      ST_BLO: if (last) begin
        nxt_state = ST_BHI;
        load      = 1'b1;
        len       = div_hi;
      end
      ST_BHI: if (last) begin
        load = 1'b1;
        if (bidx != ACK_IDX) begin
          nxt_bidx  = bidx + 4'd1;
          nxt_state = ST_BLO;
        end else if (cur == BY_PRE) begin
          nxt_state = ST_RLO;
        end else if (sda_in) begin
          nxt_state = ST_PLO;
        end else if ((cur == BY_FIRST) && ten_q) begin
          nxt_cur   = BY_SECOND;
          nxt_bidx  = 4'd0;
          nxt_state = ST_BLO;
        end else begin
          nxt_state = ST_PLO;
        end
      end
      ST_RLO: if (last) begin
        nxt_state = ST_RHI;
        load      = 1'b1;
        len       = div_hi;
      end
      ST_RHI: if (last) begin
        nxt_state = ST_START;
        nxt_cur   = BY_FIRST;
        load      = 1'b1;
        len       = div_hi;
      end
      ST_PLO: if (last) begin
        nxt_state = ST_PHI;
        load      = 1'b1;
        len       = div_hi;
      end
      default: if (last) begin
        nxt_state = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cur   <= BY_FIRST;
      bidx  <= 4'd0;
      ten_q <= 1'b0;
      done  <= 1'b0;
      nack  <= 1'b0;
    end else begin
      state <= nxt_state;
      cur   <= nxt_cur;
      bidx  <= nxt_bidx;
      done  <= fin_ok;
      if (go && (state == ST_IDLE)) begin
        ten_q <= mode_10b;
        nack  <= 1'b0;
      end else if (nack_now) begin
        nack  <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (state)
      ST_START:      sda_dl = 1'b1;
      ST_BLO, ST_BHI: sda_dl = (bidx != ACK_IDX) && !bit_val;
      ST_PLO, ST_PHI: sda_dl = 1'b1;
      default:       sda_dl = 1'b0;
    endcase
  end

  assign scl_dl = (state == ST_BLO) || (state == ST_RLO) || (state == ST_PLO);
  assign busy   = (state != ST_IDLE);

  // R4
  sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(scl_dl) && !scl_dl && (sda_dl != $past(sda_dl))) |->
      ((state == ST_START) || (state == ST_IDLE)));

  // R8
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((state == ST_PLO) && !nack));

  // R7
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack) |-> (state == ST_PLO));

  // R2
  start_after_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> ((state == ST_START) && !nack && sda_dl && !scl_dl));

endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq
  import i2c_aseq_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter logic [2*HALF_W-1:0] DIV_RST = 16'h1F1F,
  localparam int DATA_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mode_10b,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic              busy,
  output logic              done,
  output logic              nack
);

  logic              go;
  logic              prefix_pend;
  logic [BYTE_W-1:0] first_q, second_q, prefix_q;
  logic [HALF_W-1:0] div_hi, div_lo;
  logic              load, last;
  logic [HALF_W-1:0] len;

  aseq_regs #(.HALF_W(HALF_W), .DIV_RST(DIV_RST)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .busy       (busy),
    .go         (go),
    .prefix_pend(prefix_pend),
    .first_q    (first_q),
    .second_q   (second_q),
    .prefix_q   (prefix_q),
    .div_hi     (div_hi),
    .div_lo     (div_lo)
  );

  aseq_timer #(.W(HALF_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load),
    .len  (len),
    .last (last)
  );

  aseq_ctrl #(.HALF_W(HALF_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .prefix_pend(prefix_pend),
    .mode_10b   (mode_10b),
    .first_q    (first_q),
    .second_q   (second_q),
    .prefix_q   (prefix_q),
    .div_hi     (div_hi),
    .div_lo     (div_lo),
    .last       (last),
    .sda_in     (sda_in),
    .load       (load),
    .len        (len),
    .scl_dl     (scl_drive_low),
    .sda_dl     (sda_drive_low),
    .busy       (busy),
    .done       (done),
    .nack       (nack)
  );

endmodule

// File: tb/i2c_addr_seq_bench.sv
`timescale 1ns/1ps
module i2c_addr_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'h0;
  logic        mode_10b = 1'b0;
  logic        sda_in = 1'b1;
  logic        scl_drive_low, sda_drive_low, busy, done, nack;

  always #2 clk = ~clk;

  i2c_addr_seq u_i2c_addr_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mode_10b(mode_10b), .sda_in(sda_in), .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low), .busy(busy), .done(done), .nack(nack)
  );

  typedef struct {
    bit    scl;
    bit    sda;
    bit    bsy;
    bit    dn;
    bit    nk;
    bit    pull;
    string tag;
  } exp_t;

  exp_t  q[$];
  int    checks = 0;
  int    failures = 0;
  int    hi_len = 32;
  int    lo_len = 32;
  bit    exp_nack = 1'b0;
  bit    mon_on = 1'b0;
  string note = "";

  // Cycle-accurate expectation, one entry per clock.
  always @(negedge clk) begin
    if (mon_on) begin
      exp_t e;
      if (q.size() != 0) e = q.pop_front();
      else begin
        e.scl = 0; e.sda = 0; e.bsy = 0; e.dn = 0; e.nk = exp_nack; e.pull = 0;
        e.tag = "R11 idle";
      end
      checks++;
      if (scl_drive_low !== e.scl || sda_drive_low !== e.sda || busy !== e.bsy ||
          done !== e.dn || nack !== e.nk) begin
        failures++;
        $display("FAIL %s [%s] t=%0t got scl=%0b sda=%0b busy=%0b done=%0b nack=%0b exp scl=%0b sda=%0b busy=%0b done=%0b nack=%0b",
                 e.tag, note, $time, scl_drive_low, sda_drive_low, busy, done, nack,
                 e.scl, e.sda, e.bsy, e.dn, e.nk);
      end
      sda_in = e.pull ? 1'b0 : 1'b1;
    end
  end

  task automatic put(bit scl, bit sda, int n, bit dn_first, bit nk, bit pull, string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.scl = scl; e.sda = sda; e.bsy = 1'b1; e.dn = dn_first && (i == 0);
      e.nk = nk; e.pull = pull; e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic put_byte(logic [7:0] b, bit ack, string tag);
    for (int i = 7; i >= 0; i--) begin
      put(1'b1, !b[i], lo_len, 1'b0, 1'b0, 1'b0, tag);
      put(1'b0, !b[i], hi_len, 1'b0, 1'b0, 1'b0, tag);
    end
    put(1'b1, 1'b0, lo_len, 1'b0, 1'b0, ack, "R5 ack slot");
    put(1'b0, 1'b0, hi_len, 1'b0, 1'b0, ack, "R5 ack slot");
  endtask

  task automatic put_stop(bit ok, bit nk);
    string t;
    t = nk ? "R7 stop after nack" : "R8 stop after done";
    put(1'b1, 1'b1, lo_len, ok, nk, 1'b0, t);
    put(1'b0, 1'b1, hi_len, 1'b0, nk, 1'b0, t);
    exp_nack = nk;
  endtask

  task automatic model_txn(bit pre_en, logic [7:0] pb, bit pa, logic [7:0] b0, bit a0,
                           bit ten, logic [7:0] b1, bit a1);
    put(1'b0, 1'b1, hi_len, 1'b0, 1'b0, 1'b0, "R2 R3 start");
    if (pre_en) begin
      put_byte(pb, pa, "R9 prefix byte");
      put(1'b1, 1'b0, lo_len, 1'b0, 1'b0, 1'b0, "R9 restart low");
      put(1'b0, 1'b0, hi_len, 1'b0, 1'b0, 1'b0, "R9 restart high");
      put(1'b0, 1'b1, hi_len, 1'b0, 1'b0, 1'b0, "R9 restart");
    end
    put_byte(b0, a0, "R4 first byte");
    if (!a0) begin put_stop(1'b0, 1'b1); return; end
    if (ten) begin
      put_byte(b1, a1, "R6 second byte");
      if (!a1) begin put_stop(1'b0, 1'b1); return; end
    end
    put_stop(1'b1, 1'b0);
  endtask

  task automatic reg_wr(logic [1:0] s, logic [15:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic set_div(logic [15:0] d);
    reg_wr(2'd3, d);
    hi_len = int'(d[15:8]) + 1;
    lo_len = int'(d[7:0]) + 1;
  endtask

  task automatic go(bit ten, bit pre_en, logic [7:0] pb, bit pa, logic [7:0] b0, bit a0,
                    logic [7:0] b1, bit a1);
    @(negedge clk); #1;
    mode_10b = ten;
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = {8'h00, b0};
    model_txn(pre_en, pb, pa, b0, a0, ten, b1, a1);
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) begin @(negedge clk); #1; end
    repeat (3) begin @(negedge clk); #1; end
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired checks=%0d", checks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R1: idle outputs right after reset
    @(negedge clk); #1;
    checks++;
    if (scl_drive_low !== 0 || sda_drive_low !== 0 || busy !== 0 || done !== 0 || nack !== 0) begin
      failures++;
      $display("FAIL R1 reset outputs got %0b%0b%0b%0b%0b exp 00000",
               scl_drive_low, sda_drive_low, busy, done, nack);
    end
    mon_on = 1'b1;

    // R1: default divider 0x1F1F and second byte reset value 0x00 in 10-bit mode
    note = "R1 defaults";
    go(1'b1, 1'b0, 8'h00, 1'b0, 8'hF6, 1'b1, 8'h00, 1'b1);
    drain();

    // R3 R4: 7-bit read of 0x3A, asymmetric divider
    note = "R3 7-bit read";
    set_div(16'h0201);
    go(1'b0, 1'b0, 8'h00, 1'b0, 8'h75, 1'b1, 8'h00, 1'b0);
    drain();

    // R7: 7-bit address refused
    note = "R7 nack 7-bit";
    go(1'b0, 1'b0, 8'h00, 1'b0, 8'h40, 1'b0, 8'h00, 1'b0);
    drain();

    // R6: 10-bit both acknowledged
    note = "R6 10-bit ok";
    reg_wr(2'd1, 16'h005C);
    go(1'b1, 1'b0, 8'h00, 1'b0, 8'hF1, 1'b1, 8'h5C, 1'b1);
    drain();

    // R6 R7: second byte refused
    note = "R7 nack second";
    go(1'b1, 1'b0, 8'h00, 1'b0, 8'hF2, 1'b1, 8'h5C, 1'b0);
    drain();

    // R7: first header byte refused, second never sent
    note = "R7 nack first of two";
    go(1'b1, 1'b0, 8'h00, 1'b0, 8'hF4, 1'b0, 8'h5C, 1'b1);
    drain();

    // R9: prefix 0x01, its ninth slot left high (ignored)
    note = "R9 prefix 01";
    reg_wr(2'd2, 16'h0001);
    go(1'b0, 1'b1, 8'h01, 1'b0, 8'hA0, 1'b1, 8'h00, 1'b0);
    drain();

    // R9: arbitrary prefix, its slot pulled low, address refused
    note = "R9 prefix C3";
    reg_wr(2'd2, 16'h00C3);
    go(1'b0, 1'b1, 8'hC3, 1'b1, 8'h33, 1'b0, 8'h00, 1'b0);
    drain();

    // R9: prefix disarmed by the previous start
    note = "R9 prefix consumed";
    go(1'b0, 1'b0, 8'h00, 1'b0, 8'hA2, 1'b1, 8'h00, 1'b0);
    drain();

    // R9 R6: prefix ahead of a 10-bit header
    note = "R9 prefix 10-bit";
    reg_wr(2'd2, 16'h0055);
    go(1'b1, 1'b1, 8'h55, 1'b1, 8'hF0, 1'b1, 8'h5C, 1'b1);
    drain();

    // R10: writes and a mode change while busy are ignored
    note = "R10 busy writes";
    set_div(16'h0003);
    go(1'b0, 1'b0, 8'h00, 1'b0, 8'h66, 1'b1, 8'h00, 1'b0);
    repeat (10) begin @(negedge clk); #1; end
    mode_10b = 1'b1;
    wr_en = 1'b1; wr_sel = 2'd3; wr_data = 16'h0505;
    @(negedge clk); #1; wr_sel = 2'd0; wr_data = 16'h0011;
    @(negedge clk); #1; wr_sel = 2'd2; wr_data = 16'h0077;
    @(negedge clk); #1; wr_sel = 2'd1; wr_data = 16'h0099;
    @(negedge clk); #1; wr_en = 1'b0;
    drain();
    note = "R10 after busy writes";
    go(1'b0, 1'b0, 8'h00, 1'b0, 8'h2B, 1'b1, 8'h00, 1'b0);
    drain();
    go(1'b1, 1'b0, 8'h00, 1'b0, 8'hF6, 1'b1, 8'h5C, 1'b1);
    drain();

    // R3: minimum divider, one-cycle phases
    note = "R3 div zero";
    set_div(16'h0000);
    go(1'b0, 1'b0, 8'h00, 1'b0, 8'h81, 1'b1, 8'h00, 1'b0);
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule